// File: doc/BRIEF.md
# Pseudo-Random Upset Campaign Controller

This block runs a fault-injection campaign on its own, with no outside equipment choosing targets or instants. Each campaign is a series of fixed-length injection stages. At the start of every stage an 8-bit maximal-length shift register is advanced eight steps, and the result becomes the candidate target code. If the code falls inside the range of real targets, the block pulses a request to the injection sequencer at an instant inside the stage. That instant moves one position per stage across a twelve-cycle processing window, so a long campaign reaches every cycle position of the device's processing.

While the campaign runs, the block watches the device's output-valid strobe. When that strobe falls, it compares the last valid output with the expected value. After an injection, the first mismatch seen in that stage is counted as an error. A second counter records how many injections were really issued. A directed mode replaces the pseudo-random code with a fixed code, so one register can be studied alone. Start and stop controls and a programmable stage count frame the campaign, and a done flag marks its normal end.

The states are IDLE, WAIT (before the injection instant), FIRE (the injection cycle), HOLD (the stretch cycles after it) and TAIL (padding to the stage end). The transitions are: IDLE to FIRE on start, WAIT to FIRE at the instant, FIRE to HOLD, HOLD to TAIL after the stretch, HOLD or TAIL to WAIT or FIRE at the stage end, HOLD or TAIL to IDLE after the last stage, and any busy state to IDLE on stop.

Top module: `upset_campaign_ctrl`

## Requirements
- R1: After reset the block is idle. busy, done and inj_req are 0, and both counters read 0.
- R2: On start the shift register is loaded with the seed 8'h01. At every stage start it takes eight steps of s <= {s[6:0], s[7]^s[5]^s[4]^s[3]}, and the value after those steps is the stage's code on inj_code.
- R3: inj_req pulses, and upset_cnt increments, only in a stage whose code is between 1 and 141 inclusive. Codes 0 and 142 to 255 give no pulse and no count.
- R4: Each stage lasts 15 cycles. Stage s (s counted from 0) fires in cycle 15*s + (s mod 12), with cycle 0 being the first cycle after the edge that accepts start.
- R5: When directed_en is 1 at a stage start, that stage uses directed_code in place of the register value. The range rule of R3 still applies.
- R6: err_cnt increments when obs_valid falls (1 in the previous cycle, 0 now), provided obs_dut differed from obs_exp in the last cycle obs_valid was 1. The fall must lie after the FIRE cycle of a stage with a valid code, up to and including that stage's last cycle.
- R7: err_cnt grows by at most one per stage, however many mismatching falls occur in that stage.
- R8: After campaign_len stages the block returns to idle with done = 1 in cycle 15*campaign_len. done stays 0 while busy.
- R9: start while idle clears upset_cnt, err_cnt and done.
- R10: stop while busy returns the block to idle on the next cycle. No further pulses follow, done stays 0 and the counters hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a campaign (accepted when idle) |
| stop | input | 1 | Abort the running campaign |
| campaign_len | input | 16 | Number of stages to run |
| directed_en | input | 1 | Use directed_code as the target |
| directed_code | input | 8 | Fixed target code for directed mode |
| obs_valid | input | 1 | Device output-valid strobe |
| obs_dut | input | 8 | Observed device output |
| obs_exp | input | 8 | Expected device output |
| inj_req | output | 1 | One-cycle injection request to the sequencer |
| inj_code | output | 8 | Target code of the current stage |
| busy | output | 1 | Campaign running |
| done | output | 1 | Campaign completed normally |
| upset_cnt | output | 16 | Injections issued (saturating) |
| err_cnt | output | 16 | Erroneous outputs seen (saturating) |

## Verification
An error sample and the stage boundary can fall in the same cycle. The bench drives mismatching falls of obs_valid in the FIRE cycle itself, which must not count because the stage is not yet armed. It also drives one in the last cycle of a stage, which must count while the arming clears at that same edge. Two mismatching falls inside one stage check that only one is counted. A fall one cycle after the final stage checks that nothing counts once the block is idle.

// File: rtl/ucc_pkg.sv
package ucc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT,
        ST_FIRE,
        ST_HOLD,
        ST_TAIL
    } ucc_state_e;

    // One step of the maximal-length x^8+x^6+x^5+x^4+1 register
    function automatic logic [7:0] lfsr_step(input logic [7:0] s);
        return {s[6:0], s[7] ^ s[5] ^ s[4] ^ s[3]};
    endfunction

endpackage

// File: rtl/ucc_sat_cnt.sv
module ucc_sat_cnt #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] q
);
    localparam logic [W-1:0] MAXV = '1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                  q <= '0;
        else if (clr)                q <= '0;
        else if (inc && q != MAXV)   q <= q + 1'b1;
    end
endmodule

// File: rtl/ucc_lfsr.sv
module ucc_lfsr #(
    parameter logic [7:0] SEED  = 8'h01,
    parameter int         STEPS = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       reload,
    input  logic       load,
    output logic [7:0] next_val
);
    import ucc_pkg::*;

    logic [7:0] state_q;
    logic [7:0] chain [STEPS+1];

    assign chain[0] = reload ? SEED : state_q;

    for (genvar i = 0; i < STEPS; i++) begin : g_step
        assign chain[i+1] = lfsr_step(chain[i]);
    end

    assign next_val = chain[STEPS];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    state_q <= SEED;
        else if (load) state_q <= next_val;
    end
endmodule

// File: rtl/ucc_err_watch.sv
module ucc_err_watch #(
    parameter int DATA_W = 8,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              arm,
    input  logic              disarm,
    input  logic              obs_valid,
    input  logic [DATA_W-1:0] obs_dut,
    input  logic [DATA_W-1:0] obs_exp,
    output logic [CNT_W-1:0]  err_cnt
);
    logic valid_q, mis_q, armed_q;
    logic fall_bad, hit;

    assign fall_bad = valid_q && !obs_valid && mis_q;
    assign hit      = armed_q && fall_bad;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            mis_q   <= 1'b0;
            armed_q <= 1'b0;
        end else begin
            valid_q <= obs_valid;
            if (obs_valid) mis_q <= (obs_dut != obs_exp);
            if (disarm)    armed_q <= 1'b0;
            else if (arm)  armed_q <= 1'b1;
            else if (hit)  armed_q <= 1'b0;
        end
    end

    ucc_sat_cnt #(.W(CNT_W)) u_err_cnt (
        .clk(clk), .rst_n(rst_n), .clr(clear), .inc(hit), .q(err_cnt)
    );
endmodule

// File: rtl/upset_campaign_ctrl.sv
module upset_campaign_ctrl #(
    parameter logic [7:0] SEED      = 8'h01,
    parameter int         CODE_MIN  = 1,
    parameter int         CODE_MAX  = 141,
    parameter int         WIN_LEN   = 12,
    parameter int         STRETCH   = 3,
    parameter int         STAGE_LEN = 15,
    parameter int         LEN_W     = 16,
    parameter int         CNT_W     = 16,
    parameter int         DATA_W    = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              stop,
    input  logic [LEN_W-1:0]  campaign_len,
    input  logic              directed_en,
    input  logic [7:0]        directed_code,
    input  logic              obs_valid,
    input  logic [DATA_W-1:0] obs_dut,
    input  logic [DATA_W-1:0] obs_exp,
    output logic              inj_req,
    output logic [7:0]        inj_code,
    output logic              busy,
    output logic              done,
    output logic [CNT_W-1:0]  upset_cnt,
    output logic [CNT_W-1:0]  err_cnt
);
    import ucc_pkg::*;

    localparam int SC_W = $clog2(STAGE_LEN);
    localparam int PH_W = $clog2(WIN_LEN);
    localparam int HC_W = $clog2(STRETCH + 1);

    ucc_state_e        state, nxt;
    logic [SC_W-1:0]   sc;
    logic [PH_W-1:0]   ph, ph_adv;
    logic [HC_W-1:0]   hc;
    logic [LEN_W-1:0]  stages_done, len_q;
    logic [7:0]        code_q, lfsr_next, code_sel;
    logic              code_ok_q, code_ok_sel;
    logic              accept, stage_end, last_stage, stage_load;

    assign accept     = (state == ST_IDLE) && start;
    assign stage_end  = (state != ST_IDLE) && (int'(sc) == STAGE_LEN - 1);
    assign last_stage = (stages_done == len_q - 1'b1);
    assign ph_adv     = (int'(ph) == WIN_LEN - 1) ? '0 : ph + 1'b1;
    assign stage_load = (accept && campaign_len != '0) ||
                        (stage_end && !stop && !last_stage);
    assign code_sel    = directed_en ? directed_code : lfsr_next;
    assign code_ok_sel = (int'(code_sel) >= CODE_MIN) && (int'(code_sel) <= CODE_MAX);

    ucc_lfsr #(.SEED(SEED), .STEPS(8)) u_lfsr (
        .clk(clk), .rst_n(rst_n), .reload(accept),
        .load(stage_load), .next_val(lfsr_next)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // Next state
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: if (accept && campaign_len != '0) nxt = ST_FIRE;
            ST_WAIT: if (int'(sc) + 1 == int'(ph)) nxt = ST_FIRE;
            ST_FIRE: nxt = ST_HOLD;
            ST_HOLD: if (stage_end)                    nxt = last_stage ? ST_IDLE : (ph_adv == '0 ? ST_FIRE : ST_WAIT);
                     else if (int'(hc) == STRETCH - 1) nxt = ST_TAIL;
            ST_TAIL: if (stage_end)                    nxt = last_stage ? ST_IDLE : (ph_adv == '0 ? ST_FIRE : ST_WAIT);
            default: nxt = ST_IDLE;
        endcase
        if (stop && state != ST_IDLE) nxt = ST_IDLE;
    end

    // Stage bookkeeping
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sc <= '0; ph <= '0; hc <= '0;
            stages_done <= '0; len_q <= '0;
            code_q <= '0; code_ok_q <= 1'b0; done <= 1'b0;
        end else begin
            if (accept) begin
                len_q       <= campaign_len;
                stages_done <= '0;
                ph          <= '0;
                sc          <= '0;
                done        <= (campaign_len == '0);
            end else if (state != ST_IDLE) begin
                sc <= stage_end ? '0 : sc + 1'b1;
                if (stage_end) begin
                    ph          <= ph_adv;
                    stages_done <= stages_done + 1'b1;
                    if (last_stage && !stop) done <= 1'b1;
                end
            end
            hc <= (state == ST_HOLD) ? hc + 1'b1 : '0;
            if (stage_load) begin
                code_q    <= code_sel;
                code_ok_q <= code_ok_sel;
            end
        end
    end

    // Outputs
    always_comb begin
        busy     = (state != ST_IDLE);
        inj_req  = (state == ST_FIRE) && code_ok_q;
        inj_code = code_q;
    end

    ucc_sat_cnt #(.W(CNT_W)) u_upset_cnt (
        .clk(clk), .rst_n(rst_n), .clr(accept), .inc(inj_req), .q(upset_cnt)
    );

    ucc_err_watch #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_err (
        .clk(clk), .rst_n(rst_n), .clear(accept), .arm(inj_req),
        .disarm(stage_end || stop || accept),
        .obs_valid(obs_valid), .obs_dut(obs_dut), .obs_exp(obs_exp),
        .err_cnt(err_cnt)
    );
endmodule

// File: rtl/ucc_chk.sv
module ucc_chk #(
    parameter int CODE_MIN = 1,
    parameter int CODE_MAX = 141,
    parameter int CNT_W    = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             stop,
    input logic             busy,
    input logic             done,
    input logic             inj_req,
    input logic [7:0]       inj_code,
    input logic [CNT_W-1:0] upset_cnt,
    input logic [CNT_W-1:0] err_cnt
);
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !inj_req);

    a_r3_code_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        inj_req |-> (int'(inj_code) >= CODE_MIN && int'(inj_code) <= CODE_MAX));

    a_r3_no_silent_count: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !inj_req) |=> $stable(upset_cnt));

    a_r7_single_step: assert property (@(posedge clk) disable iff (!rst_n)
        !(start && !busy) |=> (err_cnt == $past(err_cnt) ||
                               err_cnt == $past(err_cnt) + CNT_W'(1)));

    a_r8_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    a_r9_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> (upset_cnt == '0 && err_cnt == '0));

    a_r10_stop_idles: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && stop) |=> (!busy && !inj_req && !done));
endmodule

bind upset_campaign_ctrl ucc_chk #(
    .CODE_MIN(CODE_MIN), .CODE_MAX(CODE_MAX), .CNT_W(CNT_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .stop(stop), .busy(busy),
    .done(done), .inj_req(inj_req), .inj_code(inj_code),
    .upset_cnt(upset_cnt), .err_cnt(err_cnt)
);

// File: tb/tb_upset_campaign_ctrl.sv
module tb_upset_campaign_ctrl;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0, stop = 1'b0;
    logic [15:0] campaign_len = '0;
    logic        directed_en = 1'b0;
    logic [7:0]  directed_code = '0;
    logic        obs_valid = 1'b0;
    logic [7:0]  obs_dut = '0, obs_exp = '0;
    logic        inj_req;
    logic [7:0]  inj_code;
    logic        busy, done;
    logic [15:0] upset_cnt, err_cnt;

    upset_campaign_ctrl dut (
        .clk(clk), .rst_n(rst_n), .start(start), .stop(stop),
        .campaign_len(campaign_len), .directed_en(directed_en),
        .directed_code(directed_code), .obs_valid(obs_valid),
        .obs_dut(obs_dut), .obs_exp(obs_exp), .inj_req(inj_req),
        .inj_code(inj_code), .busy(busy), .done(done),
        .upset_cnt(upset_cnt), .err_cnt(err_cnt)
    );

    typedef struct { int cyc; int code; } exp_t;
    exp_t sb[$];

    int checks = 0, fails = 0;
    int tick = 0;
    int t0 = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) tick <= tick + 1;

    task automatic chk(string req, bit ok, int act, int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    // Monitor: every injection request must match the head of the scoreboard (R2 R3 R4 R5)
    always @(negedge clk) begin
        if (rst_n && inj_req) begin
            if (sb.size() == 0) begin
                chk("R3 unexpected inj_req", 1'b0, int'(inj_code), -1);
            end else begin
                exp_t e;
                e = sb.pop_front();
                chk("R4 fire cycle", (tick - t0) == e.cyc, tick - t0, e.cyc);
                chk("R2 inj_code", int'(inj_code) == e.code, int'(inj_code), e.code);
            end
        end
    end

    function automatic logic [7:0] step8(input logic [7:0] s);
        logic [7:0] v;
        v = s;
        for (int i = 0; i < 8; i++) v = {v[6:0], v[7] ^ v[5] ^ v[4] ^ v[3]};
        return v;
    endfunction

    // Driver: push expected injections for a campaign, up to a cycle limit
    task automatic plan(input int len, input bit den, input int dcode,
                        input int limit, output int n_ok);
        logic [7:0] s;
        int code, cyc;
        s = 8'h01;
        n_ok = 0;
        for (int k = 0; k < len; k++) begin
            s = step8(s);
            code = den ? dcode : int'(s);
            cyc = 15 * k + (k % 12);
            if (code >= 1 && code <= 141 && cyc <= limit) begin
                exp_t e;
                e.cyc = cyc; e.code = code;
                sb.push_back(e);
                n_ok++;
            end
        end
    endtask

    task automatic launch(input int len, input bit den, input int dcode);
        @(negedge clk);
        campaign_len = 16'(len); directed_en = den; directed_code = 8'(dcode);
        start = 1'b1;
        t0 = tick + 1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic goto(input int c);
        while (tick - t0 < c) @(negedge clk);
    endtask

    task automatic drive_obs(input bit v, input int d, input int e);
        obs_valid = v; obs_dut = 8'(d); obs_exp = 8'(e);
    endtask

    initial begin
        int n;
        repeat (3) @(negedge clk);
        chk("R1 busy", busy == 0, busy, 0);
        chk("R1 done", done == 0, done, 0);
        chk("R1 inj_req", inj_req == 0, inj_req, 0);
        chk("R1 counters", upset_cnt == 0 && err_cnt == 0, upset_cnt + err_cnt, 0);
        rst_n = 1'b1;

        // Pseudo-random campaign: codes, filtering and timing (R2 R3 R4 R8)
        plan(20, 1'b0, 0, 100000, n);
        launch(20, 1'b0, 0);
        goto(299);
        chk("R8 busy before end", busy == 1 && done == 0, done, 0);
        goto(300);
        chk("R8 done at end", done == 1 && busy == 0, done, 1);
        chk("R3 upset count", int'(upset_cnt) == n, int'(upset_cnt), n);
        chk("R2 all expected fired", sb.size() == 0, sb.size(), 0);

        // Directed boundary codes (R5 R3)
        plan(3, 1'b1, 141, 100000, n);
        launch(3, 1'b1, 141);
        goto(46);
        chk("R5 directed 141 count", upset_cnt == 3, int'(upset_cnt), 3);
        plan(2, 1'b1, 0, 100000, n);
        launch(2, 1'b1, 0);
        goto(31);
        chk("R3 code 0 no count", upset_cnt == 0, int'(upset_cnt), 0);
        plan(2, 1'b1, 142, 100000, n);
        launch(2, 1'b1, 142);
        goto(31);
        chk("R3 code 142 no count", upset_cnt == 0, int'(upset_cnt), 0);

        // Stop in the middle (R10)
        plan(10, 1'b0, 0, 20, n);
        launch(10, 1'b0, 0);
        goto(20);
        stop = 1'b1;
        goto(21);
        stop = 1'b0;
        chk("R10 idle after stop", busy == 0, busy, 0);
        chk("R10 done stays low", done == 0, done, 0);
        chk("R10 counter held", int'(upset_cnt) == n, int'(upset_cnt), n);
        goto(80);
        chk("R10 no later injections", sb.size() == 0 && upset_cnt == 16'(n), int'(upset_cnt), n);

        // Error counting with directed code 50 (R6 R7)
        plan(4, 1'b1, 50, 100000, n);
        launch(4, 1'b1, 50);
        goto(5);  drive_obs(1, 1, 0);
        goto(6);  drive_obs(0, 0, 0);
        goto(8);  drive_obs(1, 2, 0);
        goto(9);  drive_obs(0, 0, 0);
        goto(12);
        chk("R7 one error per stage", err_cnt == 1, int'(err_cnt), 1);
        goto(15); drive_obs(1, 4, 0);
        goto(16); drive_obs(0, 0, 0);
        goto(20); drive_obs(1, 3, 3);
        goto(21); drive_obs(0, 0, 0);
        goto(30);
        chk("R6 fall in FIRE cycle and match ignored", err_cnt == 1, int'(err_cnt), 1);
        goto(43); drive_obs(1, 7, 1);
        goto(44); drive_obs(0, 0, 0);
        goto(45);
        chk("R6 fall in last stage cycle counted", err_cnt == 2, int'(err_cnt), 2);
        goto(59);
        chk("R8 busy in final cycle", busy == 1 && done == 0, busy, 1);
        drive_obs(1, 9, 0);
        goto(60); drive_obs(0, 0, 0);
        chk("R8 done after four stages", done == 1 && upset_cnt == 4, int'(upset_cnt), 4);
        goto(62);
        chk("R6 fall after campaign ignored", err_cnt == 2, int'(err_cnt), 2);

        // Start clears counters (R9), invalid code never arms (R6)
        plan(1, 1'b1, 200, 100000, n);
        launch(1, 1'b1, 200);
        chk("R9 counters cleared", err_cnt == 0 && upset_cnt == 0, int'(err_cnt), 0);
        chk("R9 done cleared", done == 0, done, 0);
        goto(3);  drive_obs(1, 5, 0);
        goto(4);  drive_obs(0, 0, 0);
        goto(15);
        chk("R6 no error without injection", err_cnt == 0, int'(err_cnt), 0);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            fails++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule